// File: doc/BRIEF.md
# In-place radix-2 FFT address sequencer

This unit drives the addressing for an iterative, in-place radix-2 FFT of N = 2^LOG2N points that uses a single butterfly engine, one data RAM and a twiddle coefficient ROM. A controller selects a job with a two-bit mode code and a one-cycle start pulse. The unit then runs the job and returns to idle.

There are three jobs. A load job produces a linear write address for each valid input sample. A transform job walks every stage and every butterfly. For each butterfly it issues the two operand read addresses and the twiddle index. It also replays each read address as a write-back address after the fixed butterfly latency. An unload job reads the RAM in bit-reversed address order, so that the results come out in natural frequency order.

The unit raises a one-cycle flag when a load or unload finishes, when each stage has issued its last write-back, and when the whole transform is complete. It does not hold data, coefficients or arithmetic. All outputs are registered.

Top module: `fft_addr_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, every enable and flag output is 0 and `busy_o` is 0.
- R2: `start_i` is sampled only while the unit is idle. Mode 1 starts a load, mode 2 starts a transform, mode 3 starts an unload, and mode 0 does nothing. A start pulse during a running job has no effect on any output.
- R3: During a load, every cycle with `in_valid_i` high produces `wr_en_o` one cycle later. The addresses run 0, 1, …, N−1 in order, gaps in `in_valid_i` are allowed, and `io_done_o` rises together with write N−1. Afterwards the unit is idle and ignores `in_valid_i`.
- R4: An unload issues N reads on consecutive cycles, starting the cycle after the start. Read m has the address of m with its LOG2N bits reversed, and `io_done_o` rises with the last read.
- R5: In a transform, each butterfly takes BF_CYCLES cycles. Operand A is read in the first cycle and operand B in the second, and there is no read in the remaining cycles. For stage s with span h = 2^s and butterfly k, A = (k div h)·2h + (k mod h) and B = A + h.
- R6: Butterflies run k = 0 … N/2−1 within a stage, and stages run s = 0 … LOG2N−1.
- R7: `coef_addr_o` equals (k mod h) shifted left by LOG2N−1−s. It is valid in the cycle of the A read.
- R8: Every transform read reappears as `wr_en_o` with the same address exactly WR_LAT cycles later. No write-back ever targets the address being read in the same cycle.
- R9: `stage_done_o` is a single-cycle pulse. It comes no earlier than the stage's last write-back, and with the default parameters it comes in that very cycle. The next stage's first read follows in the next cycle.
- R10: `fft_done_o` rises together with the final stage's `stage_done_o`, and `busy_o` is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts the job selected by `mode_i` when idle |
| mode_i | input | 2 | 0 none, 1 load, 2 transform, 3 unload |
| in_valid_i | input | 1 | Input sample present this cycle (load job) |
| busy_o | output | 1 | A job is running |
| rd_en_o | output | 1 | RAM read strobe |
| rd_addr_o | output | LOG2N | RAM read address |
| coef_addr_o | output | LOG2N-1 | Twiddle ROM index |
| wr_en_o | output | 1 | RAM write strobe |
| wr_addr_o | output | LOG2N | RAM write address |
| io_done_o | output | 1 | Load or unload finished |
| stage_done_o | output | 1 | Last write-back of a stage issued |
| fft_done_o | output | 1 | Transform finished |

## Verification
The hardest case to reach from the ports is the boundary between stages. There, the last write-backs of one stage are still in the delay line while the next stage waits to issue its first reads. A wrong drain condition shows up only as a flag that is one cycle off, or as an overlapping read. The bench runs complete transforms and compares every output in every cycle against a behavioural schedule. That schedule is built from the butterfly timing rule and the latency, so any early, late or duplicated stage flag is caught. A start request injected in the middle of a transform, with input samples also offered, checks that a running job cannot be disturbed.

// File: rtl/fft_ag_pkg.sv
package fft_ag_pkg;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_LOAD = 2'd1,
    MODE_FFT  = 2'd2,
    MODE_DUMP = 2'd3
  } ag_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CALC,
    ST_DRAIN,
    ST_DUMP
  } ag_state_e;

endpackage

// File: rtl/fft_ag_index.sv
// Butterfly operand and twiddle index mapping for one (stage, butterfly) pair.
module fft_ag_index #(
  parameter int LOG2N = 4,
  localparam int AW = LOG2N,
  localparam int KW = LOG2N - 1,
  localparam int SW = (LOG2N > 2) ? $clog2(LOG2N) : 1
) (
  input  logic [SW-1:0] stage,
  input  logic [KW-1:0] bfly,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b,
  output logic [KW-1:0] coef
);

  always_comb begin
    int si;
    si = int'(stage);
    addr_a = '0;
    addr_b = '0;
    // A: a zero bit is inserted at position s into the butterfly index
    for (int i = 0; i < AW; i++) begin
      for (int m = 0; m < KW; m++) begin
        if ((m == i && i < si) || (m == i - 1 && i > si)) begin
          addr_a[i] = bfly[m];
        end
      end
      addr_b[i] = (i == si) ? 1'b1 : addr_a[i];
    end
    // twiddle: low s bits of k moved to the top of the index
    coef = '0;
    for (int j = 0; j < KW; j++) begin
      for (int m = 0; m < KW; m++) begin
        if (m == j + si - KW) begin
          coef[j] = bfly[m];
        end
      end
    end
  end

endmodule

// File: rtl/fft_ag_bitrev.sv
// Reverses the bit order of an address.
module fft_ag_bitrev #(
  parameter int W = 4
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign dout[i] = din[W-1-i];
  end

endmodule

// File: rtl/fft_ag_wrdelay.sv
// Shift chain carrying read addresses towards their write-back slot.
module fft_ag_wrdelay #(
  parameter int AW    = 4,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [AW-1:0] in_a,
  output logic          tail_v,
  output logic [AW-1:0] tail_a,
  output logic          ahead_v
);

  logic [DEPTH-1:0] vld;
  logic [AW-1:0]    adr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      vld[0] <= in_v;
      for (int i = 1; i < DEPTH; i++) begin
        vld[i] <= vld[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    adr[0] <= in_a;
    for (int i = 1; i < DEPTH; i++) begin
      adr[i] <= adr[i-1];
    end
  end

  assign tail_v = vld[DEPTH-1];
  assign tail_a = adr[DEPTH-1];

  if (DEPTH > 1) begin : g_ahead
    assign ahead_v = |vld[DEPTH-2:0];
  end else begin : g_noahead
    assign ahead_v = 1'b0;
  end

endmodule

// File: rtl/fft_addr_gen.sv
// Address sequencer for an in-place radix-2 FFT with one butterfly engine.
module fft_addr_gen
  import fft_ag_pkg::*;
#(
  parameter int LOG2N     = 4,
  parameter int BF_CYCLES = 4,
  parameter int WR_LAT    = 5,
  localparam int N     = 1 << LOG2N,
  localparam int HALF  = N / 2,
  localparam int AW    = LOG2N,
  localparam int KW    = LOG2N - 1,
  localparam int SW    = (LOG2N > 2) ? $clog2(LOG2N) : 1,
  localparam int PW    = (BF_CYCLES > 2) ? $clog2(BF_CYCLES) : 1,
  localparam int DEPTH = WR_LAT - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic          in_valid_i,
  output logic          busy_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [KW-1:0] coef_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          io_done_o,
  output logic          stage_done_o,
  output logic          fft_done_o
);

  ag_state_e     state;
  logic [AW-1:0] io_cnt;
  logic [SW-1:0] stg;
  logic [KW-1:0] bfly;
  logic [PW-1:0] ph;
  logic          rd_calc;

  logic [AW-1:0] op_a, op_b, rev_addr;
  logic [KW-1:0] tw_idx;
  logic          tail_v, ahead_v;
  logic [AW-1:0] tail_a;

  fft_ag_index #(.LOG2N(LOG2N)) u_index (
    .stage  (stg),
    .bfly   (bfly),
    .addr_a (op_a),
    .addr_b (op_b),
    .coef   (tw_idx)
  );

  fft_ag_bitrev #(.W(AW)) u_rev (
    .din  (io_cnt),
    .dout (rev_addr)
  );

  fft_ag_wrdelay #(.AW(AW), .DEPTH(DEPTH)) u_dly (
    .clk     (clk),
    .rst     (rst),
    .in_v    (rd_en_o & rd_calc),
    .in_a    (rd_addr_o),
    .tail_v  (tail_v),
    .tail_a  (tail_a),
    .ahead_v (ahead_v)
  );

  assign busy_o = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      io_cnt       <= '0;
      stg          <= '0;
      bfly         <= '0;
      ph           <= '0;
      rd_calc      <= 1'b0;
      rd_en_o      <= 1'b0;
      rd_addr_o    <= '0;
      coef_addr_o  <= '0;
      wr_en_o      <= 1'b0;
      wr_addr_o    <= '0;
      io_done_o    <= 1'b0;
      stage_done_o <= 1'b0;
      fft_done_o   <= 1'b0;
    end else begin
      rd_en_o      <= 1'b0;
      rd_calc      <= 1'b0;
      io_done_o    <= 1'b0;
      stage_done_o <= 1'b0;
      fft_done_o   <= 1'b0;

      // write port: linear fill while loading, delayed read-back otherwise
      if (state == ST_LOAD) begin
        wr_en_o   <= in_valid_i;
        wr_addr_o <= io_cnt;
      end else begin
        wr_en_o   <= tail_v;
        wr_addr_o <= tail_a;
      end

      case (state)
        ST_IDLE: begin
          if (start_i) begin
            case (ag_mode_e'(mode_i))
              MODE_LOAD: begin
                state  <= ST_LOAD;
                io_cnt <= '0;
              end
              MODE_FFT: begin
                state <= ST_CALC;
                stg   <= '0;
                bfly  <= '0;
                ph    <= '0;
              end
              MODE_DUMP: begin
                state  <= ST_DUMP;
                io_cnt <= '0;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end

        ST_LOAD: begin
          if (in_valid_i) begin
            io_cnt <= io_cnt + AW'(1);
            if (io_cnt == AW'(N - 1)) begin
              io_done_o <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end

        ST_CALC: begin
          if (ph == PW'(0)) begin
            rd_en_o     <= 1'b1;
            rd_calc     <= 1'b1;
            rd_addr_o   <= op_a;
            coef_addr_o <= tw_idx;
          end else if (ph == PW'(1)) begin
            rd_en_o   <= 1'b1;
            rd_calc   <= 1'b1;
            rd_addr_o <= op_b;
          end
          if (ph == PW'(BF_CYCLES - 1)) begin
            ph <= '0;
            if (bfly == KW'(HALF - 1)) begin
              bfly  <= '0;
              state <= ST_DRAIN;
            end else begin
              bfly <= bfly + KW'(1);
            end
          end else begin
            ph <= ph + PW'(1);
          end
        end

        ST_DRAIN: begin
          // done once only the final write-back (if any) remains in the chain
          if (!ahead_v && !(rd_en_o && rd_calc)) begin
            stage_done_o <= 1'b1;
            if (stg == SW'(LOG2N - 1)) begin
              fft_done_o <= 1'b1;
              stg        <= '0;
              state      <= ST_IDLE;
            end else begin
              stg   <= stg + SW'(1);
              state <= ST_CALC;
            end
          end
        end

        ST_DUMP: begin
          rd_en_o   <= 1'b1;
          rd_addr_o <= rev_addr;
          io_cnt    <= io_cnt + AW'(1);
          if (io_cnt == AW'(N - 1)) begin
            io_done_o <= 1'b1;
            state     <= ST_IDLE;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fft_addr_gen_chk.sv
module fft_addr_gen_chk #(
  parameter int LOG2N = 4,
  localparam int AW = LOG2N
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          busy_o,
  input logic          rd_en_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o,
  input logic          io_done_o,
  input logic          stage_done_o,
  input logic          fft_done_o
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rd_en_o && !wr_en_o && !busy_o && !io_done_o && !stage_done_o && !fft_done_o));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> !busy_o);

  // R3 and R4: the finish flag accompanies a transfer
  assert_io_done_xfer_R3: assert property (@(posedge clk) disable iff (rst)
    io_done_o |-> (wr_en_o || rd_en_o));

  assert_no_rdwr_collision_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en_o && wr_en_o) |-> (rd_addr_o != wr_addr_o));

  assert_stage_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    stage_done_o |=> !stage_done_o);

  assert_final_stage_R10: assert property (@(posedge clk) disable iff (rst)
    fft_done_o |-> (stage_done_o && !busy_o));

endmodule

bind fft_addr_gen fft_addr_gen_chk #(.LOG2N(LOG2N)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .rd_en_o      (rd_en_o),
  .rd_addr_o    (rd_addr_o),
  .wr_en_o      (wr_en_o),
  .wr_addr_o    (wr_addr_o),
  .io_done_o    (io_done_o),
  .stage_done_o (stage_done_o),
  .fft_done_o   (fft_done_o)
);

// File: tb/sim_fft_addr_gen.sv
module sim_fft_addr_gen;

  localparam int LOG2N = 4;
  localparam int BFC   = 4;
  localparam int LAT   = 5;
  localparam int N     = 1 << LOG2N;
  localparam int AW    = LOG2N;
  localparam int KW    = LOG2N - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic in_valid_i = 1'b0;
  logic busy_o, rd_en_o, wr_en_o, io_done_o, stage_done_o, fft_done_o;
  logic [AW-1:0] rd_addr_o, wr_addr_o;
  logic [KW-1:0] coef_addr_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit mon_on = 1'b0;

  // expectations keyed by the cycle count seen at the sampling edge
  int e_ra[int];
  int e_co[int];
  int e_wa[int];
  bit e_io[int];
  bit e_sd[int];
  bit e_fd[int];

  fft_addr_gen #(.LOG2N(LOG2N), .BF_CYCLES(BFC), .WR_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .in_valid_i(in_valid_i), .busy_o(busy_o), .rd_en_o(rd_en_o),
    .rd_addr_o(rd_addr_o), .coef_addr_o(coef_addr_o), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .io_done_o(io_done_o),
    .stage_done_o(stage_done_o), .fft_done_o(fft_done_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  function automatic int bitrev(input int v);
    int r = 0;
    for (int i = 0; i < LOG2N; i++) if (v[i]) r |= 1 << (LOG2N - 1 - i);
    return r;
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      chk("R4 R5 R6", "rd_en", int'(rd_en_o), int'(e_ra.exists(cyc)));
      if (e_ra.exists(cyc)) chk("R4 R5 R6", "rd_addr", int'(rd_addr_o), e_ra[cyc]);
      if (e_co.exists(cyc)) chk("R7", "coef", int'(coef_addr_o), e_co[cyc]);
      chk("R3 R8", "wr_en", int'(wr_en_o), int'(e_wa.exists(cyc)));
      if (e_wa.exists(cyc)) chk("R3 R8", "wr_addr", int'(wr_addr_o), e_wa[cyc]);
      chk("R3 R4", "io_done", int'(io_done_o), int'(e_io.exists(cyc)));
      chk("R9", "stage_done", int'(stage_done_o), int'(e_sd.exists(cyc)));
      chk("R10", "fft_done", int'(fft_done_o), int'(e_fd.exists(cyc)));
    end
  end

  // Transform schedule: stage lasts N/2 butterflies plus drain (LAT-2 cycles here)
  function automatic int sched_fft(input int c0);
    int i = 0;
    for (int s = 0; s < LOG2N; s++) begin
      int h = 1 << s;
      for (int k = 0; k < N / 2; k++) begin
        int a = (k / h) * 2 * h + (k % h);
        e_ra[c0 + 1 + i] = a;
        e_co[c0 + 1 + i] = (k % h) << (LOG2N - 1 - s);
        e_ra[c0 + 2 + i] = a + h;
        e_wa[c0 + 1 + i + LAT] = a;
        e_wa[c0 + 2 + i + LAT] = a + h;
        i += BFC;
      end
      i += LAT - 2;
      e_sd[c0 + i] = 1'b1;
    end
    e_fd[c0 + i] = 1'b1;
    return i;
  endfunction

  task automatic go(input logic [1:0] m, output int c0);
    @(negedge clk);
    start_i = 1'b1;
    mode_i  = m;
    c0 = cyc + 1;
  endtask

  task automatic run_load(input int gap);
    int c0, j;
    go(2'd1, c0);
    @(negedge clk);
    start_i = 1'b0;
    j = 0;
    for (int t = 0; j < N; t++) begin
      in_valid_i = (gap == 0) || ((t % gap) != 1);
      if (in_valid_i) begin
        e_wa[cyc + 1] = j;
        if (j == N - 1) e_io[cyc + 1] = 1'b1;
        j++;
      end
      @(negedge clk);
    end
    // R3: valid after the last sample is ignored
    in_valid_i = 1'b1;
    repeat (3) @(negedge clk);
    in_valid_i = 1'b0;
    chk("R3", "busy after load", int'(busy_o), 0);
  endtask

  task automatic run_fft(input bit poke);
    int c0, len;
    go(2'd2, c0);
    len = sched_fft(c0);
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; cyc <= c0 + len + 2; t++) begin
      chk("R10", "busy", int'(busy_o), int'(cyc < c0 + len));
      // R2: a load request with samples in the middle of the transform is ignored
      if (poke && t == 20) begin start_i = 1'b1; mode_i = 2'd1; in_valid_i = 1'b1; end
      if (poke && t == 21) begin start_i = 1'b0; end
      if (poke && t == 30) in_valid_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic run_dump();
    int c0;
    go(2'd3, c0);
    for (int m = 0; m < N; m++) e_ra[c0 + 1 + m] = bitrev(m);
    e_io[c0 + N] = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (N + 3) @(negedge clk);
    chk("R4", "busy after unload", int'(busy_o), 0);
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy in reset", int'(busy_o), 0);
    chk("R1", "rd_en in reset", int'(rd_en_o), 0);
    chk("R1", "wr_en in reset", int'(wr_en_o), 0);
    chk("R1", "flags in reset", int'({io_done_o, stage_done_o, fft_done_o}), 0);
    rst = 1'b0;
    mon_on = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy_o), 0);
    // R2: mode 0 start and stray valid do nothing
    go(2'd0, c0);
    in_valid_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    in_valid_i = 1'b0;
    chk("R2", "busy after mode 0", int'(busy_o), 0);
    run_load(3);
    run_fft(1'b1);
    run_dump();
    run_load(0);
    run_fft(1'b0);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule